// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Clock

This block is a free-running time-of-day counter. On every clock edge it adds a programmable increment to two timestamps that are kept side by side. The increment is a fixed-point nanosecond value: a few whole nanoseconds plus a 16-bit fraction. Because the fraction is carried, a clock whose period is not a whole number of nanoseconds (for example 6.4 ns) accumulates without error. One timestamp splits time into seconds and nanoseconds and wraps the nanosecond part once per second. The other timestamp is a single flat count of nanoseconds that never wraps.

Software or a servo elsewhere on the chip steers the clock through four strobed controls. It can load either timestamp outright, replace the per-cycle period, apply a bounded offset correction, or set a periodic drift term. Each control is a single-cycle valid pulse with no ready. The block accepts it on the edge where valid is high, so there is no back-pressure, and the driver must not rely on a value being held. The block reports a step pulse after any load and a once-per-second pulse when the seconds field advances.

Top module: `tod_clock`

## Requirements
- R1: While reset is high and in the cycle after it, both timestamps read zero and `pps_o` and `step_o` are low. The period returns to its default, the drift returns to its default with its cycle counter at zero, and any pending offset correction is dropped.
- R2: With default settings, each edge adds 6 ns plus 0x6666 units of 2^-16 ns. After 10 edges from reset, the flat timestamp equals 0x400000 (64 ns), which includes two default drift additions.
- R3: A drift amount (ns plus fraction) is added on every edge where the drift cycle counter has reached rate minus one, and the counter then returns to zero. The default is 2 fraction units every 5th edge. A drift strobe replaces the amount and the rate and restarts the counter, so the first addition falls on the rate-th edge after the strobe edge. A rate of 0 disables drift.
- R4: A period strobe replaces the per-cycle ns and fraction. The new period applies from the next edge on, and the strobe edge still uses the old period.
- R5: An offset strobe with count N adds adj_ns plus adj_frac as an extra increment on each of the N edges that follow the strobe edge, then stops. A new strobe replaces any correction still in progress, and the strobe edge still applies the old correction.
- R6: The 96-bit timestamp holds seconds in bits [95:48], whole nanoseconds in [47:16] and the fraction in [15:0]. When the sub-second part reaches 1e9 ns, 1e9 ns is subtracted, seconds increments, and `pps_o` is high for exactly the following cycle.
- R7: A load strobe for either timestamp sets it to the supplied value exactly, with no increment on that edge, and `step_o` is high in the next cycle only. The two loads are independent of each other.
- R8: Both timestamps receive the same increment on every edge that is not a load. The 64-bit flat timestamp (bits [15:0] fraction) never wraps at one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld96_vld_i | input | 1 | Load strobe for the seconds/ns timestamp |
| ld96_ts_i | input | 96 | Value to load into the seconds/ns timestamp |
| ld64_vld_i | input | 1 | Load strobe for the flat timestamp |
| ld64_ts_i | input | 64 | Value to load into the flat timestamp |
| per_vld_i | input | 1 | Period update strobe |
| per_ns_i | input | 4 | New period, whole ns |
| per_frac_i | input | 16 | New period, fraction |
| adj_vld_i | input | 1 | Offset correction strobe |
| adj_ns_i | input | 4 | Offset step, whole ns |
| adj_frac_i | input | 16 | Offset step, fraction |
| adj_cnt_i | input | 16 | Number of edges the offset step applies |
| drf_vld_i | input | 1 | Drift update strobe |
| drf_ns_i | input | 4 | Drift amount, whole ns |
| drf_frac_i | input | 16 | Drift amount, fraction |
| drf_rate_i | input | 16 | Edges between drift additions (0 disables drift) |
| ts96_o | output | 96 | Seconds/ns timestamp |
| ts64_o | output | 64 | Flat ns timestamp |
| step_o | output | 1 | High for one cycle after a load |
| pps_o | output | 1 | High for one cycle after a seconds rollover |

## Verification
The assertions assume that a loaded sub-second value is below one second, and that a single edge's increment never exceeds one second. Under those assumptions the nanosecond field stays in range and a seconds pulse can never repeat on consecutive cycles. They also assume that every drift strobe restarts the drift counter. The stimulus loads only values within one second, and keeps every period, drift and offset field at a few nanoseconds. Each scenario starts from a fresh reset so that the drift phase is known.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int SEC_W  = 48;
  localparam int SUB_W  = 48;
  localparam int TS96_W = SEC_W + SUB_W;
  localparam int TS64_W = 64;
  localparam longint unsigned NS_PER_SEC = 64'd1000000000;
endpackage

// File: rtl/tod_rate_gen.sv
`timescale 1ns/1ps
module tod_rate_gen #(
  parameter int PER_NS_W     = 4,
  parameter int OFF_NS_W     = 4,
  parameter int DRF_NS_W     = 4,
  parameter int FRAC_W       = 16,
  parameter int CNT_W        = 16,
  parameter int INC_W        = 22,
  parameter int DEF_PER_NS   = 6,
  parameter int DEF_PER_FRAC = 'h6666,
  parameter bit DRIFT_EN     = 1'b1,
  parameter int DEF_DRF_NS   = 0,
  parameter int DEF_DRF_FRAC = 2,
  parameter int DEF_DRF_RATE = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                per_vld_i,
  input  logic [PER_NS_W-1:0] per_ns_i,
  input  logic [FRAC_W-1:0]   per_frac_i,
  input  logic                adj_vld_i,
  input  logic [OFF_NS_W-1:0] adj_ns_i,
  input  logic [FRAC_W-1:0]   adj_frac_i,
  input  logic [CNT_W-1:0]    adj_cnt_i,
  input  logic                drf_vld_i,
  input  logic [DRF_NS_W-1:0] drf_ns_i,
  input  logic [FRAC_W-1:0]   drf_frac_i,
  input  logic [CNT_W-1:0]    drf_rate_i,
  output logic [INC_W-1:0]    inc_o
);
  localparam int PER_W = PER_NS_W + FRAC_W;
  localparam int OFF_W = OFF_NS_W + FRAC_W;
  localparam int DRF_W = DRF_NS_W + FRAC_W;

  logic [PER_W-1:0] per_q;
  logic [OFF_W-1:0] adj_q;
  logic [CNT_W-1:0] adj_left_q;
  logic [INC_W-1:0] drf_term;

  // Per-cycle period register
  always_ff @(posedge clk) begin
    if (rst) per_q <= {PER_NS_W'(DEF_PER_NS), FRAC_W'(DEF_PER_FRAC)};
    else if (per_vld_i) per_q <= {per_ns_i, per_frac_i};
  end

  // Bounded offset correction: counts down one step per edge
  always_ff @(posedge clk) begin
    if (rst) begin
      adj_q      <= '0;
      adj_left_q <= '0;
    end else if (adj_vld_i) begin
      adj_q      <= {adj_ns_i, adj_frac_i};
      adj_left_q <= adj_cnt_i;
    end else if (adj_left_q != '0) begin
      adj_left_q <= adj_left_q - 1'b1;
    end
  end

  generate
    if (DRIFT_EN) begin : g_drift
      logic [DRF_W-1:0] drf_q;
      logic [CNT_W-1:0] rate_q;
      logic [CNT_W-1:0] cnt_q;
      logic             due;

      assign due = (rate_q != '0) && (cnt_q == rate_q - 1'b1);

      always_ff @(posedge clk) begin
        if (rst) begin
          drf_q  <= {DRF_NS_W'(DEF_DRF_NS), FRAC_W'(DEF_DRF_FRAC)};
          rate_q <= CNT_W'(DEF_DRF_RATE);
          cnt_q  <= '0;
        end else if (drf_vld_i) begin
          drf_q  <= {drf_ns_i, drf_frac_i};
          rate_q <= drf_rate_i;
          cnt_q  <= '0;
        end else if (due) begin
          cnt_q  <= '0;
        end else if (rate_q != '0) begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end

      assign drf_term = due ? INC_W'(drf_q) : '0;

      // R3: the cycle counter stays below an active rate
      a_r3_drift_cnt_below_rate: assert property (@(posedge clk) disable iff (rst)
        (rate_q != '0) |-> (cnt_q < rate_q))
        else $error("drift counter out of range");
    end else begin : g_no_drift
      assign drf_term = '0;
    end
  endgenerate

  assign inc_o = INC_W'(per_q)
               + ((adj_left_q != '0) ? INC_W'(adj_q) : INC_W'(0))
               + drf_term;

  // R5: an active correction loses one step per edge unless replaced
  a_r5_adj_countdown: assert property (@(posedge clk) disable iff (rst)
    (adj_left_q != '0 && !adj_vld_i) |=> (adj_left_q == $past(adj_left_q) - 1'b1))
    else $error("offset countdown broken");
endmodule

// File: rtl/tod_sec_ns_acc.sv
`timescale 1ns/1ps
module tod_sec_ns_acc
  import tod_pkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int INC_W  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_vld_i,
  input  logic [TS96_W-1:0] ld_ts_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic [TS96_W-1:0] ts_o,
  output logic              pps_o
);
  localparam int SUM_W = SUB_W + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(NS_PER_SEC) << FRAC_W;

  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic [SUM_W-1:0] sum;
  logic             wrap;
  logic [SUB_W-1:0] sub_nxt;

  always_comb begin
    sum     = {1'b0, sub_q} + SUM_W'(inc_i);
    wrap    = (sum >= LIMIT);
    sub_nxt = wrap ? SUB_W'(sum - LIMIT) : sum[SUB_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      sub_q <= '0;
      pps_o <= 1'b0;
    end else if (ld_vld_i) begin
      sec_q <= ld_ts_i[TS96_W-1:SUB_W];
      sub_q <= ld_ts_i[SUB_W-1:0];
      pps_o <= 1'b0;
    end else begin
      sec_q <= sec_q + SEC_W'(wrap);
      sub_q <= sub_nxt;
      pps_o <= wrap;
    end
  end

  assign ts_o = {sec_q, sub_q};

  // R6: a rollover pulse lasts a single cycle
  a_r6_pps_single: assert property (@(posedge clk) disable iff (rst)
    pps_o |=> !pps_o)
    else $error("pps held longer than one cycle");

  // R6: seconds only move together with a pulse, absent a load
  a_r6_sec_with_pps: assert property (@(posedge clk) disable iff (rst)
    (!$past(ld_vld_i) && !$past(rst) && sec_q != $past(sec_q)) |-> pps_o)
    else $error("seconds advanced without pps");
endmodule

// File: rtl/tod_flat_acc.sv
`timescale 1ns/1ps
module tod_flat_acc
  import tod_pkg::*;
#(
  parameter int INC_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_vld_i,
  input  logic [TS64_W-1:0] ld_ts_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic [TS64_W-1:0] ts_o
);
  always_ff @(posedge clk) begin
    if (rst) ts_o <= '0;
    else if (ld_vld_i) ts_o <= ld_ts_i;
    else ts_o <= ts_o + TS64_W'(inc_i);
  end
endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
  import tod_pkg::*;
#(
  parameter int PER_NS_W     = 4,
  parameter int OFF_NS_W     = 4,
  parameter int DRF_NS_W     = 4,
  parameter int FRAC_W       = 16,
  parameter int CNT_W        = 16,
  parameter int DEF_PER_NS   = 6,
  parameter int DEF_PER_FRAC = 'h6666,
  parameter bit DRIFT_EN     = 1'b1,
  parameter int DEF_DRF_NS   = 0,
  parameter int DEF_DRF_FRAC = 2,
  parameter int DEF_DRF_RATE = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld96_vld_i,
  input  logic [95:0]         ld96_ts_i,
  input  logic                ld64_vld_i,
  input  logic [63:0]         ld64_ts_i,
  input  logic                per_vld_i,
  input  logic [PER_NS_W-1:0] per_ns_i,
  input  logic [FRAC_W-1:0]   per_frac_i,
  input  logic                adj_vld_i,
  input  logic [OFF_NS_W-1:0] adj_ns_i,
  input  logic [FRAC_W-1:0]   adj_frac_i,
  input  logic [CNT_W-1:0]    adj_cnt_i,
  input  logic                drf_vld_i,
  input  logic [DRF_NS_W-1:0] drf_ns_i,
  input  logic [FRAC_W-1:0]   drf_frac_i,
  input  logic [CNT_W-1:0]    drf_rate_i,
  output logic [95:0]         ts96_o,
  output logic [63:0]         ts64_o,
  output logic                step_o,
  output logic                pps_o
);
  localparam int NS_A  = (PER_NS_W > OFF_NS_W) ? PER_NS_W : OFF_NS_W;
  localparam int NS_M  = (NS_A > DRF_NS_W) ? NS_A : DRF_NS_W;
  localparam int INC_W = NS_M + 2 + FRAC_W;
  localparam logic [63:0] LIMIT64 = NS_PER_SEC << FRAC_W;

  logic [INC_W-1:0] inc;

  tod_rate_gen #(
    .PER_NS_W(PER_NS_W), .OFF_NS_W(OFF_NS_W), .DRF_NS_W(DRF_NS_W),
    .FRAC_W(FRAC_W), .CNT_W(CNT_W), .INC_W(INC_W),
    .DEF_PER_NS(DEF_PER_NS), .DEF_PER_FRAC(DEF_PER_FRAC),
    .DRIFT_EN(DRIFT_EN), .DEF_DRF_NS(DEF_DRF_NS),
    .DEF_DRF_FRAC(DEF_DRF_FRAC), .DEF_DRF_RATE(DEF_DRF_RATE)
  ) u_rate (
    .clk(clk), .rst(rst),
    .per_vld_i(per_vld_i), .per_ns_i(per_ns_i), .per_frac_i(per_frac_i),
    .adj_vld_i(adj_vld_i), .adj_ns_i(adj_ns_i), .adj_frac_i(adj_frac_i),
    .adj_cnt_i(adj_cnt_i),
    .drf_vld_i(drf_vld_i), .drf_ns_i(drf_ns_i), .drf_frac_i(drf_frac_i),
    .drf_rate_i(drf_rate_i),
    .inc_o(inc)
  );

  tod_sec_ns_acc #(.FRAC_W(FRAC_W), .INC_W(INC_W)) u_sec_ns (
    .clk(clk), .rst(rst),
    .ld_vld_i(ld96_vld_i), .ld_ts_i(ld96_ts_i),
    .inc_i(inc), .ts_o(ts96_o), .pps_o(pps_o)
  );

  tod_flat_acc #(.INC_W(INC_W)) u_flat (
    .clk(clk), .rst(rst),
    .ld_vld_i(ld64_vld_i), .ld_ts_i(ld64_ts_i),
    .inc_i(inc), .ts_o(ts64_o)
  );

  always_ff @(posedge clk) begin
    if (rst) step_o <= 1'b0;
    else step_o <= ld96_vld_i | ld64_vld_i;
  end

  // R7: any load is reported on the next cycle
  a_r7_step_after_load: assert property (@(posedge clk) disable iff (rst)
    (ld96_vld_i || ld64_vld_i) |=> step_o)
    else $error("load not flagged");

  // R6: sub-second field stays below one second when no load landed
  a_r6_ns_below_second: assert property (@(posedge clk) disable iff (rst)
    !step_o |-> (64'(ts96_o[47:0]) < LIMIT64))
    else $error("sub-second field out of range");

  // R8: both timestamps advance by the same amount
  a_r8_lockstep: assert property (@(posedge clk) disable iff (rst)
    (!step_o && !$past(rst)) |->
      ((ts64_o - $past(ts64_o)) ==
       (64'(ts96_o[47:0]) - 64'($past(ts96_o[47:0])) + (pps_o ? LIMIT64 : 64'd0))))
    else $error("timestamps out of lockstep");
endmodule

// File: tb/tod_clock_tb.sv
`timescale 1ns/1ps
module tod_clock_tb;
  localparam longint P    = 64'd419430;          // 6 ns + 0x6666
  localparam longint LIM  = 64'd65536000000000;   // 1 s in 2^-16 ns

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic        ld96_vld_i = 0; logic [95:0] ld96_ts_i = '0;
  logic        ld64_vld_i = 0; logic [63:0] ld64_ts_i = '0;
  logic        per_vld_i = 0;  logic [3:0] per_ns_i = '0; logic [15:0] per_frac_i = '0;
  logic        adj_vld_i = 0;  logic [3:0] adj_ns_i = '0; logic [15:0] adj_frac_i = '0;
  logic [15:0] adj_cnt_i = '0;
  logic        drf_vld_i = 0;  logic [3:0] drf_ns_i = '0; logic [15:0] drf_frac_i = '0;
  logic [15:0] drf_rate_i = '0;
  logic [95:0] ts96_o; logic [63:0] ts64_o; logic step_o, pps_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  tod_clock u_dut (
    .clk(clk), .rst(rst),
    .ld96_vld_i(ld96_vld_i), .ld96_ts_i(ld96_ts_i),
    .ld64_vld_i(ld64_vld_i), .ld64_ts_i(ld64_ts_i),
    .per_vld_i(per_vld_i), .per_ns_i(per_ns_i), .per_frac_i(per_frac_i),
    .adj_vld_i(adj_vld_i), .adj_ns_i(adj_ns_i), .adj_frac_i(adj_frac_i),
    .adj_cnt_i(adj_cnt_i),
    .drf_vld_i(drf_vld_i), .drf_ns_i(drf_ns_i), .drf_frac_i(drf_frac_i),
    .drf_rate_i(drf_rate_i),
    .ts96_o(ts96_o), .ts64_o(ts64_o), .step_o(step_o), .pps_o(pps_o)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Leaves the bench at a negedge with zero edges since reset release
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ts96 after reset", ts96_o, 96'd0);
    chk("R1 ts64 after reset", 96'(ts64_o), 96'd0);
    chk("R1 pps after reset", 96'(pps_o), 96'd0);
    chk("R1 step after reset", 96'(step_o), 96'd0);
  endtask

  task automatic t_default_rate();
    do_reset();
    adv(4);
    chk("R2 ts64 after 4 edges", 96'(ts64_o), 96'(4 * P));
    adv(6);
    chk("R2 ts64 after 10 edges", 96'(ts64_o), 96'h400000);
    chk("R8 ts96 sub-second matches", 96'(ts96_o[47:0]), 96'h400000);
    chk("R6 seconds still zero", 96'(ts96_o[95:48]), 96'd0);
  endtask

  task automatic t_load_and_rollover();
    longint v;
    v = LIM - 2 * P + 1;
    do_reset();
    ld96_ts_i = {48'd7, 48'(v)}; ld96_vld_i = 1'b1;
    ld64_ts_i = 64'(v);          ld64_vld_i = 1'b1;
    adv(1);
    ld96_vld_i = 1'b0; ld64_vld_i = 1'b0;
    chk("R7 ts96 loaded exactly", ts96_o, {48'd7, 48'(v)});
    chk("R7 ts64 loaded exactly", 96'(ts64_o), 96'(v));
    chk("R7 step after load", 96'(step_o), 96'd1);
    adv(1);
    chk("R7 step drops", 96'(step_o), 96'd0);
    chk("R6 no pps before second", 96'(pps_o), 96'd0);
    chk("R7 ts64 resumes counting", 96'(ts64_o), 96'(v + P));
    adv(1);
    chk("R6 pps on rollover", 96'(pps_o), 96'd1);
    chk("R6 seconds advanced", 96'(ts96_o[95:48]), 96'd8);
    chk("R6 sub-second wrapped", 96'(ts96_o[47:0]), 96'd1);
    chk("R8 ts64 does not wrap", 96'(ts64_o), 96'(LIM + 1));
    adv(1);
    chk("R6 pps single cycle", 96'(pps_o), 96'd0);
    chk("R6 counting after wrap", 96'(ts96_o[47:0]), 96'(1 + P));
  endtask

  task automatic t_load_independent();
    do_reset();
    ld64_ts_i = 64'd1000; ld64_vld_i = 1'b1;
    adv(1);
    ld64_vld_i = 1'b0;
    chk("R7 ts96 unaffected by 64-bit load", 96'(ts96_o[47:0]), 96'(P));
    chk("R7 ts64 only loaded", 96'(ts64_o), 96'd1000);
    chk("R7 step on either load", 96'(step_o), 96'd1);
  endtask

  task automatic t_period();
    do_reset();
    per_ns_i = 4'd7; per_frac_i = 16'h1000; per_vld_i = 1'b1;
    adv(1);
    per_vld_i = 1'b0;
    chk("R4 strobe edge uses old period", 96'(ts64_o), 96'(P));
    adv(3);
    chk("R4 new period applied", 96'(ts64_o), 96'(P + 3 * 64'd462848));
  endtask

  task automatic t_drift();
    do_reset();
    drf_ns_i = 4'd1; drf_frac_i = 16'd20; drf_rate_i = 16'd3; drf_vld_i = 1'b1;
    adv(1);
    drf_vld_i = 1'b0;
    adv(2);
    chk("R3 no drift before rate edges", 96'(ts64_o), 96'(3 * P));
    adv(4);
    chk("R3 new drift every 3rd edge", 96'(ts64_o), 96'(7 * P + 2 * 64'd65556));
    do_reset();
    drf_rate_i = 16'd0; drf_vld_i = 1'b1;
    adv(1);
    drf_vld_i = 1'b0;
    adv(9);
    chk("R3 rate zero disables drift", 96'(ts64_o), 96'(10 * P));
  endtask

  task automatic t_adjust();
    do_reset();
    adj_ns_i = 4'd2; adj_frac_i = 16'd5; adj_cnt_i = 16'd3; adj_vld_i = 1'b1;
    adv(1);
    adj_vld_i = 1'b0;
    chk("R5 strobe edge has no offset", 96'(ts64_o), 96'(P));
    adv(3);
    chk("R5 offset on next 3 edges", 96'(ts64_o), 96'(4 * P + 3 * 64'd131077));
    adv(2);
    chk("R5 offset stops", 96'(ts64_o), 96'(6 * P + 3 * 64'd131077 + 2));
    do_reset();
    adj_ns_i = 4'd2; adj_frac_i = 16'd5; adj_cnt_i = 16'd10; adj_vld_i = 1'b1;
    adv(1);
    adj_vld_i = 1'b0;
    adv(1);
    adj_ns_i = 4'd1; adj_frac_i = 16'd0; adj_cnt_i = 16'd1; adj_vld_i = 1'b1;
    adv(1);
    adj_vld_i = 1'b0;
    adv(3);
    chk("R5 new offset overrides", 96'(ts64_o),
        96'(6 * P + 2 * 64'd131077 + 64'd65536 + 2));
  endtask

  initial begin
    t_reset();
    t_default_rate();
    t_load_and_rollover();
    t_load_independent();
    t_period();
    t_drift();
    t_adjust();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule